// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a small direct-mapped data cache placed between a processor-side request port and a plain word-wide main-memory port. Every memory block has exactly one line it can occupy. Each request is checked against the stored tag of that line. A hit is served from the cache storage. A miss fetches the whole line from memory, one word at a time, and then serves the request from the refilled line.

Two parameters select the write behaviour, and all four combinations share one datapath. `WRITE_BACK` selects between write-back, where writes stay in the cache and the line is marked dirty, and write-through, where every write also goes to memory. `WRITE_ALLOC` selects what happens on a write miss. With allocation, the line is brought in first and the write then hits. Without it, the write goes straight to memory and the cache is left as it was.

The processor side takes one request at a time. It holds its ready signal low from acceptance until the one-cycle completion pulse. The memory side is a request/acknowledge handshake: the request and address stay stable until an acknowledge arrives.

Top module: `cache_wc`

## Requirements
- R1: A read whose tag matches a valid line returns the stored word with no memory transaction. Addresses are word addresses: the low log2(WORDS) bits select the word, the next log2(LINES) bits select the line, and the rest form the tag.
- R2: A read miss performs WORDS memory reads of the addressed line, in ascending word order, then returns the requested word.
- R3: In write-back mode a write hit updates only the cache and causes no memory transaction; a later read of that address returns the new data.
- R4: In write-back mode, a miss on a line that is valid and dirty first writes all WORDS words of the old line to memory, then fetches the new line.
- R5: A miss on a clean or invalid line fetches the new line without any memory write.
- R6: In write-through mode each write hit updates the cache and performs exactly one memory write of that word.
- R7: With write allocation, a write miss fetches the line and then writes into the cache; later reads of the line hit.
- R8: Without write allocation, a write miss performs exactly one memory write and leaves the cache unchanged, so a following read of that address misses.
- R9: `cpuReady` is low from the cycle after a request is accepted until completion, including every memory transaction; `cpuDone` is a single-cycle pulse.
- R10: Reset invalidates and cleans every line, raises `cpuReady`, and leaves no memory request pending.
- R11: Once raised, `memReq` stays high with stable `memAddr` and `memWe` until `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Processor request, accepted when `cpuReady` is high |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | High when a new request can be taken |
| cpuDone | output | 1 | One-cycle completion pulse |
| cpuRdata | output | DATA_W | Read data, valid with `cpuDone` on a read |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory acknowledge, one cycle per word |
| memRdata | input | DATA_W | Memory read data, valid with `memAck` |

## Verification
The hardest case to reach from the ports is the dirty eviction. A line must first be written while resident and then displaced by an access with the same index and a different tag. Only a later miss on the original address shows whether the written-back data reached memory. The stimulus table chains exactly such sequences: fill, write hit, conflicting read, re-read. It checks the count of memory reads and writes at every step against a fixed-latency memory model. A second instance, built for write-through without allocation, gets directed write-miss and write-hit sequences.

// File: rtl/cache_wc_pkg.sv
package cache_wc_pkg;

  typedef enum logic [1:0] {
    ADDR_REQ   = 2'd0,
    ADDR_EVICT = 2'd1,
    ADDR_FILL  = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     latchReq;
    logic     wrHitWord;
    logic     setDirty;
    logic     fillWord;
    logic     fillDone;
    logic     cntClr;
    logic     cntInc;
    addrSel_e addrSel;
  } dpCtrl_t;

endpackage

// File: rtl/cache_wc_dp.sv
module cache_wc_dp
  import cache_wc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              hit,
  output logic              lineValid,
  output logic              lineDirty,
  output logic              reqWe,
  output logic              cntLast,
  output logic [DATA_W-1:0] cpuRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [OFF_W-1:0]  cnt;

  logic [OFF_W-1:0] reqOff;
  logic [IDX_W-1:0] reqIdx;
  logic [TAG_W-1:0] reqTag;

  assign reqOff = reqAddr[OFF_W-1:0];
  assign reqIdx = reqAddr[OFF_W +: IDX_W];
  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];

  logic [TAG_W-1:0]                 tagArr   [LINES];
  logic [WORDS-1:0][DATA_W-1:0]     lineData [LINES];
  logic [LINES-1:0]                 validArr;
  logic [LINES-1:0]                 dirtyArr;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
      cnt      <= '0;
    end else begin
      if (ctl.latchReq) begin
        reqAddr  <= cpuAddr;
        reqWdata <= cpuWdata;
        reqWe    <= cpuWe;
      end
      if (ctl.cntClr)      cnt <= '0;
      else if (ctl.cntInc) cnt <= cnt + 1'b1;
    end
  end

  // One storage slice per line; only the addressed slice reacts to strobes.
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic                         validQ;
    logic                         dirtyQ;
    logic [TAG_W-1:0]             tagQ;
    logic [WORDS-1:0][DATA_W-1:0] wordQ;
    logic                         sel;

    assign sel = (reqIdx == IDX_W'(l));

    always_ff @(posedge clk) begin
      if (rst) begin
        validQ <= 1'b0;
        dirtyQ <= 1'b0;
        tagQ   <= '0;
      end else if (sel) begin
        if (ctl.fillDone) begin
          validQ <= 1'b1;
          dirtyQ <= 1'b0;
          tagQ   <= reqTag;
        end
        if (ctl.setDirty) dirtyQ <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        if (ctl.fillWord)  wordQ[cnt]    <= memRdata;
        if (ctl.wrHitWord) wordQ[reqOff] <= reqWdata;
      end
    end

    assign validArr[l] = validQ;
    assign dirtyArr[l] = dirtyQ;
    assign tagArr[l]   = tagQ;
    assign lineData[l] = wordQ;
  end

  logic [WORDS-1:0][DATA_W-1:0] selLine;
  assign selLine   = lineData[reqIdx];
  assign lineValid = validArr[reqIdx];
  assign lineDirty = dirtyArr[reqIdx];
  assign hit       = lineValid && (tagArr[reqIdx] == reqTag);
  assign cntLast   = (cnt == OFF_W'(WORDS - 1));
  assign cpuRdata  = selLine[reqOff];

  always_comb begin
    unique case (ctl.addrSel)
      ADDR_EVICT: begin
        memAddr  = {tagArr[reqIdx], reqIdx, cnt};
        memWdata = selLine[cnt];
      end
      ADDR_FILL: begin
        memAddr  = {reqTag, reqIdx, cnt};
        memWdata = reqWdata;
      end
      default: begin
        memAddr  = reqAddr;
        memWdata = reqWdata;
      end
    endcase
  end

endmodule

// File: rtl/cache_wc_ctrl.sv
module cache_wc_ctrl
  import cache_wc_pkg::*;
#(
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cpuReq,
  input  logic    memAck,
  input  logic    hit,
  input  logic    lineValid,
  input  logic    lineDirty,
  input  logic    reqWe,
  input  logic    cntLast,
  output dpCtrl_t ctl,
  output logic    cpuReady,
  output logic    cpuDone,
  output logic    memReq,
  output logic    memWe
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_EVICT, ST_FILL, ST_MEMWR
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = ADDR_REQ;
    cpuReady    = 1'b0;
    cpuDone     = 1'b0;
    memReq      = 1'b0;
    memWe       = 1'b0;
    nextState   = state;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuReq) begin
          ctl.latchReq = 1'b1;
          nextState    = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          if (!reqWe) begin
            cpuDone   = 1'b1;
            nextState = ST_IDLE;
          end else begin
            ctl.wrHitWord = 1'b1;
            if (WRITE_BACK) begin
              ctl.setDirty = 1'b1;
              cpuDone      = 1'b1;
              nextState    = ST_IDLE;
            end else begin
              nextState = ST_MEMWR;
            end
          end
        end else if (reqWe && !WRITE_ALLOC) begin
          nextState = ST_MEMWR;
        end else begin
          ctl.cntClr = 1'b1;
          nextState  = (WRITE_BACK && lineValid && lineDirty) ? ST_EVICT : ST_FILL;
        end
      end
      ST_EVICT: begin
        memReq      = 1'b1;
        memWe       = 1'b1;
        ctl.addrSel = ADDR_EVICT;
        if (memAck) begin
          ctl.cntInc = 1'b1;
          if (cntLast) nextState = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq      = 1'b1;
        ctl.addrSel = ADDR_FILL;
        if (memAck) begin
          ctl.fillWord = 1'b1;
          ctl.cntInc   = 1'b1;
          if (cntLast) begin
            ctl.fillDone = 1'b1;
            nextState    = ST_LOOKUP;
          end
        end
      end
      ST_MEMWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          cpuDone   = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/cache_wc.sv
module cache_wc
  import cache_wc_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 32,
  parameter int LINES       = 8,
  parameter int WORDS       = 4,
  parameter bit WRITE_BACK  = 1'b1,
  parameter bit WRITE_ALLOC = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuDone,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  dpCtrl_t ctl;
  logic    hit, lineValid, lineDirty, reqWe, cntLast;

  cache_wc_ctrl #(
    .WRITE_BACK (WRITE_BACK),
    .WRITE_ALLOC(WRITE_ALLOC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cpuReq   (cpuReq),
    .memAck   (memAck),
    .hit      (hit),
    .lineValid(lineValid),
    .lineDirty(lineDirty),
    .reqWe    (reqWe),
    .cntLast  (cntLast),
    .ctl      (ctl),
    .cpuReady (cpuReady),
    .cpuDone  (cpuDone),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  cache_wc_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LINES (LINES),
    .WORDS (WORDS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .hit      (hit),
    .lineValid(lineValid),
    .lineDirty(lineDirty),
    .reqWe    (reqWe),
    .cntLast  (cntLast),
    .cpuRdata (cpuRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/cache_wc_chk.sv
module cache_wc_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReady,
  input logic              cpuDone,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memAck
);
  // R11: a pending memory request keeps its address and direction
  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R9: no new processor request is taken while memory is busy
  a_r9_ready_low_mem: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);

  // R9: completion lasts a single cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    cpuDone |=> !cpuDone);

  // R9: completion never coincides with ready
  a_r9_done_not_ready: assert property (@(posedge clk) disable iff (rst)
    cpuDone |-> !cpuReady);

  // R10: first cycle out of reset is idle
  a_r10_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cpuReady && !memReq && !cpuDone));
endmodule

bind cache_wc cache_wc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cpuReady(cpuReady),
  .cpuDone (cpuDone),
  .memReq  (memReq),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memAck  (memAck)
);

// File: tb/cache_wc_mem.sv
module cache_wc_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              memReq,
  input  logic              memWe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic              memAck,
  output logic [DATA_W-1:0] memRdata
);
  logic [DATA_W-1:0] store [1 << ADDR_W];
  int waitCnt = 0;
  int rdCount = 0;
  int wrCount = 0;

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) store[i] = DATA_W'(32'h1000_0000 + i);
    memAck   = 1'b0;
    memRdata = '0;
  end

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (memReq && !memAck) begin
      if (waitCnt == LAT - 1) begin
        waitCnt <= 0;
        memAck  <= 1'b1;
        if (memWe) begin
          store[memAddr] <= memWdata;
          wrCount <= wrCount + 1;
        end else begin
          memRdata <= store[memAddr];
          rdCount  <= rdCount + 1;
        end
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end
endmodule

// File: tb/cache_wc_bench.sv
module cache_wc_bench;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cpuReq   [2];
  logic          cpuWe    [2];
  logic [AW-1:0] cpuAddr  [2];
  logic [DW-1:0] cpuWdata [2];
  logic          cpuReady [2];
  logic          cpuDone  [2];
  logic [DW-1:0] cpuRdata [2];
  logic          memReq   [2];
  logic          memWe    [2];
  logic [AW-1:0] memAddr  [2];
  logic [DW-1:0] memWdata [2];
  logic          memAck   [2];
  logic [DW-1:0] memRdata [2];

  // instance 0: write-back with allocation (defaults)
  cache_wc u_cache_wc (
    .clk(clk), .rst(rst),
    .cpuReq(cpuReq[0]), .cpuWe(cpuWe[0]), .cpuAddr(cpuAddr[0]), .cpuWdata(cpuWdata[0]),
    .cpuReady(cpuReady[0]), .cpuDone(cpuDone[0]), .cpuRdata(cpuRdata[0]),
    .memReq(memReq[0]), .memWe(memWe[0]), .memAddr(memAddr[0]), .memWdata(memWdata[0]),
    .memAck(memAck[0]), .memRdata(memRdata[0]));

  // instance 1: write-through without allocation
  cache_wc #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u_cache_wc_wt (
    .clk(clk), .rst(rst),
    .cpuReq(cpuReq[1]), .cpuWe(cpuWe[1]), .cpuAddr(cpuAddr[1]), .cpuWdata(cpuWdata[1]),
    .cpuReady(cpuReady[1]), .cpuDone(cpuDone[1]), .cpuRdata(cpuRdata[1]),
    .memReq(memReq[1]), .memWe(memWe[1]), .memAddr(memAddr[1]), .memWdata(memWdata[1]),
    .memAck(memAck[1]), .memRdata(memRdata[1]));

  cache_wc_mem #(.ADDR_W(AW), .DATA_W(DW)) u_mem0 (
    .clk(clk), .memReq(memReq[0]), .memWe(memWe[0]), .memAddr(memAddr[0]),
    .memWdata(memWdata[0]), .memAck(memAck[0]), .memRdata(memRdata[0]));
  cache_wc_mem #(.ADDR_W(AW), .DATA_W(DW)) u_mem1 (
    .clk(clk), .memReq(memReq[1]), .memWe(memWe[1]), .memAddr(memAddr[1]),
    .memWdata(memWdata[1]), .memAck(memAck[1]), .memRdata(memRdata[1]));

  int nChecks = 0;
  int nFails  = 0;
  logic [DW-1:0] shadow [2][1 << AW];

  // {we, addr[9:0], wdata[31:0], expected reads[2:0], expected writes[2:0], req[3:0]}
  // 8 lines, 4 words: addr 0x010/0x090 share line 4, 0x200/0x300 share line 0
  localparam logic [52:0] VECS [11] = '{
    {1'b0, 10'h010, 32'h0,         3'd4, 3'd0, 4'd2},  // R2 cold miss
    {1'b0, 10'h013, 32'h0,         3'd0, 3'd0, 4'd1},  // R1 hit
    {1'b1, 10'h011, 32'hCAFE0011,  3'd0, 3'd0, 4'd3},  // R3 write hit stays local
    {1'b0, 10'h011, 32'h0,         3'd0, 3'd0, 4'd3},  // R3 new data visible
    {1'b0, 10'h090, 32'h0,         3'd4, 3'd4, 4'd4},  // R4 dirty eviction
    {1'b0, 10'h011, 32'h0,         3'd4, 3'd0, 4'd5},  // R5 clean replacement
    {1'b1, 10'h200, 32'hBEEF0200,  3'd4, 3'd0, 4'd7},  // R7 allocate on write miss
    {1'b0, 10'h201, 32'h0,         3'd0, 3'd0, 4'd7},  // R7 line now resident
    {1'b1, 10'h203, 32'hBEEF0203,  3'd0, 3'd0, 4'd3},  // R3
    {1'b0, 10'h300, 32'h0,         3'd4, 3'd4, 4'd4},  // R4
    {1'b0, 10'h200, 32'h0,         3'd4, 3'd0, 4'd2}   // R2 reads back evicted write
  };

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int rdCnt(input int d);
    return (d == 0) ? u_mem0.rdCount : u_mem1.rdCount;
  endfunction
  function automatic int wrCnt(input int d);
    return (d == 0) ? u_mem0.wrCount : u_mem1.wrCount;
  endfunction

  task automatic access(input int d, input logic we, input logic [AW-1:0] a,
                        input logic [DW-1:0] wd, output logic [DW-1:0] rd,
                        output int nRd, output int nWr);
    int r0, w0, n;
    logic readyBad;
    @(negedge clk);
    r0 = rdCnt(d); w0 = wrCnt(d);
    cpuReq[d] = 1'b1; cpuWe[d] = we; cpuAddr[d] = a; cpuWdata[d] = wd;
    @(negedge clk);
    cpuReq[d] = 1'b0;
    n = 0; readyBad = 1'b0;
    while (!cpuDone[d] && n < 500) begin
      if (cpuReady[d]) readyBad = 1'b1;
      @(negedge clk);
      n++;
    end
    if (cpuReady[d]) readyBad = 1'b1;
    check("R9 ready low while busy", DW'(readyBad), '0);
    check("R9 completion seen", DW'(cpuDone[d]), 1);
    rd  = cpuRdata[d];
    nRd = rdCnt(d) - r0;
    nWr = wrCnt(d) - w0;
    if (we) shadow[d][a] = wd;
    @(negedge clk);
    check("R9 done is one pulse", DW'(cpuDone[d]), '0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [DW-1:0] rd;
    int nRd, nWr;
    for (int d = 0; d < 2; d++) begin
      cpuReq[d] = 1'b0; cpuWe[d] = 1'b0; cpuAddr[d] = '0; cpuWdata[d] = '0;
      for (int i = 0; i < (1 << AW); i++) shadow[d][i] = 32'h1000_0000 + i;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      check("R10 ready after reset", DW'(cpuReady[d]), 1);
      check("R10 no mem request after reset", DW'(memReq[d]), '0);
    end

    // table walk on the write-back / allocate instance
    for (int i = 0; i < 11; i++) begin
      logic [52:0] v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d vec %0d", v[3:0], i);
      access(0, v[52], v[51:42], v[41:10], rd, nRd, nWr);
      check({tag, " mem reads"}, DW'(nRd), DW'(v[9:7]));
      check({tag, " mem writes"}, DW'(nWr), DW'(v[6:4]));
      if (!v[52]) check({tag, " read data"}, rd, shadow[0][v[51:42]]);
      if (i == 4) check("R4 written-back word in memory", u_mem0.store[10'h011], 32'hCAFE0011);
    end

    // write-through, no allocation
    access(1, 1'b1, 10'h040, 32'h5A5A0040, rd, nRd, nWr);
    check("R8 miss write count", DW'(nWr), 1);
    check("R8 miss no fill", DW'(nRd), 0);
    access(1, 1'b0, 10'h040, '0, rd, nRd, nWr);
    check("R8 cache untouched so read misses", DW'(nRd), 4);
    check("R8 read data", rd, shadow[1][10'h040]);
    access(1, 1'b1, 10'h041, 32'h5A5A0041, rd, nRd, nWr);
    check("R6 hit write count", DW'(nWr), 1);
    check("R6 memory updated", u_mem1.store[10'h041], 32'h5A5A0041);
    access(1, 1'b0, 10'h041, '0, rd, nRd, nWr);
    check("R1 hit after write-through", DW'(nRd + nWr), 0);
    check("R6 cache updated", rd, 32'h5A5A0041);
    access(1, 1'b0, 10'h0C0, '0, rd, nRd, nWr);
    check("R5 conflict without writeback", DW'(nWr), 0);
    check("R5 conflict fill", DW'(nRd), 4);

    // reset mid-run invalidates lines
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R10 ready after second reset", DW'(cpuReady[0]), 1);
    access(0, 1'b0, 10'h200, '0, rd, nRd, nWr);
    check("R10 previously resident line misses", DW'(nRd), 4);
    check("R10 clean miss no write", DW'(nWr), 0);
    check("R10 read data", rd, shadow[0][10'h200]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule